// File: doc/BRIEF.md
# Flash Busy and Power-Mode Controller

This block tracks the operating mode of a serial flash device. The command sequencer reports each command when chip select rises on a whole byte. The controller then owns three things: the write-in-progress flag, the write enable latch, and the choice of which commands are acted on in the current mode. Program, erase and status-write commands start a self-timed busy cycle. When that cycle ends, the busy flag drops, the write enable latch clears, and a one-clock completion pulse is raised.

Deep power down is entered through a timed entry phase and left through a timed release phase. Each phase counts its own number of clock cycles. While the device is in deep power down, only the release opcode is acted on. All durations are clock-cycle parameters that stand in for the real program, erase, status-write, entry and release times. The reset input stands in for power-on detection and leaves the device in standby with the latch cleared.

The mode output uses this 3-bit code: standby 0, selected 1, busy 2, entering power down 3, power down 4, releasing 5. The transitions are named as follows:
- select: standby to selected when chip select is low.
- deselect: selected to standby when chip select is high.
- write start: standby or selected to busy, on an accepted write-type command while the latch is set.
- write done: busy to standby when the cycle count expires.
- sleep: standby or selected to entering power down, on opcode B9.
- sleep done: entering power down to power down when the count expires.
- wake: power down to releasing, on opcode AB.
- wake done: releasing to standby when the count expires.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: After reset, mode is 0 (standby), and wip, wel, busy_done and cmd_taken are all 0.
- R2: In standby or selected mode, a command ending with opcode 06 sets wel and opcode 04 clears it. In both cases cmd_taken is high for the cycle after cmd_end.
- R3: In standby or selected mode with wel at 1, the write-type opcodes start a busy cycle. These are 02 (page program), 20 (sector erase), 52 or D8 (block erase), 60 or C7 (chip erase) and 01 (status write). From the cycle after cmd_end, mode is 2 and wip is 1 for exactly the parameter length of that command (PP_CYC, SE_CYC, BE_CYC, CE_CYC, SR_CYC).
- R4: In the cycle where wip falls, wel reads 0 and busy_done is high for exactly one clock. mode then reads 0.
- R5: A write-type opcode that ends while wel is 0 is ignored: mode stays 0 and cmd_taken stays 0.
- R6: While busy, every command is ignored, including 04 and AB. wel and mode do not change, and the cycle length is not affected.
- R7: Opcode B9 in standby or selected mode gives mode 3 for DP_CYC cycles from the cycle after cmd_end, then mode 4.
- R8: In mode 4, every opcode except AB is ignored: 06 does not set wel, 02 does not start a cycle, and cmd_taken stays 0.
- R9: Opcode AB in mode 4 gives mode 5 for RES_CYC cycles from the cycle after cmd_end, then mode 0.
- R10: Opcode AB in standby is taken (cmd_taken is 1) and mode stays 0 with no delay.
- R11: In standby, chip select low gives mode 1 on the next cycle. Chip select high in mode 1 gives mode 0 on the next cycle.
- R12: An opcode with no mode effect, for example 03 (read), is not taken and changes neither mode nor wel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; stands in for power-on detection |
| cs_n | input | 1 | Chip select level, active low |
| cmd_end | input | 1 | One-cycle pulse: chip select rose at the end of a whole-byte command |
| cmd_code | input | 8 | Opcode of the command that ended, valid with cmd_end |
| mode | output | 3 | Current operating mode code |
| wip | output | 1 | Write in progress |
| wel | output | 1 | Write enable latch |
| busy_done | output | 1 | One-cycle pulse at the end of a self-timed cycle |
| cmd_taken | output | 1 | One-cycle pulse: the last ended command was acted on |

## Verification
Each of the seven write-type opcodes is issued once the latch is set. A scoreboard predicts the clock cycle in which its completion pulse arrives, and this separates the per-command lengths from each other. The same opcodes are also sent with the latch clear and during power down, which shows that the latch guard and the power-down guard both work. The enable, disable and release opcodes are sent in the middle of a busy cycle to show that busy ignores them. Release is sent both from standby and from power down, which tells the immediate case apart from the timed one.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

    typedef enum logic [2:0] {
        M_STANDBY   = 3'd0,
        M_SELECTED  = 3'd1,
        M_BUSY      = 3'd2,
        M_SLEEPING  = 3'd3,
        M_ASLEEP    = 3'd4,
        M_WAKING    = 3'd5
    } pwr_mode_t;

    typedef enum logic [3:0] {
        K_NONE, K_WREN, K_WRDI, K_WRSR, K_PROG,
        K_SECT, K_BLK, K_CHIP, K_SLEEP, K_WAKE
    } cmd_kind_t;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_SECT  = 8'h20;
    localparam logic [7:0] OP_BLK_A = 8'h52;
    localparam logic [7:0] OP_BLK_B = 8'hD8;
    localparam logic [7:0] OP_CHIP_A = 8'h60;
    localparam logic [7:0] OP_CHIP_B = 8'hC7;
    localparam logic [7:0] OP_SLEEP = 8'hB9;
    localparam logic [7:0] OP_WAKE  = 8'hAB;

endpackage

// File: rtl/flash_cmd_kind.sv
module flash_cmd_kind
    import flash_pwr_pkg::*;
(
    input  logic [7:0] code,
    output cmd_kind_t  kind
);
    always_comb begin
        case (code)
            OP_WREN:             kind = K_WREN;
            OP_WRDI:             kind = K_WRDI;
            OP_WRSR:             kind = K_WRSR;
            OP_PROG:             kind = K_PROG;
            OP_SECT:             kind = K_SECT;
            OP_BLK_A, OP_BLK_B:  kind = K_BLK;
            OP_CHIP_A, OP_CHIP_B: kind = K_CHIP;
            OP_SLEEP:            kind = K_SLEEP;
            OP_WAKE:             kind = K_WAKE;
            default:             kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/flash_cycle_timer.sv
module flash_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= len - 1'b1;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
    import flash_pwr_pkg::*;
#(
    parameter int PP_CYC  = 20,
    parameter int SE_CYC  = 40,
    parameter int BE_CYC  = 60,
    parameter int CE_CYC  = 80,
    parameter int SR_CYC  = 12,
    parameter int DP_CYC  = 6,
    parameter int RES_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       cmd_end,
    input  logic [7:0] cmd_code,
    output logic [2:0] mode,
    output logic       wip,
    output logic       wel,
    output logic       busy_done,
    output logic       cmd_taken
);
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAX_CYC = max2(max2(max2(PP_CYC, SE_CYC), max2(BE_CYC, CE_CYC)),
                                  max2(SR_CYC, max2(DP_CYC, RES_CYC)));
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    pwr_mode_t        state, nxt;
    cmd_kind_t        kind;
    logic             expired, load, take;
    logic [CNT_W-1:0] len, wr_len;
    logic             is_write;

    flash_cmd_kind i_kind (.code(cmd_code), .kind(kind));

    flash_cycle_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .len(len), .expired(expired)
    );

    always_comb begin
        is_write = 1'b1;
        wr_len   = '0;
        case (kind)
            K_PROG:  wr_len = CNT_W'(PP_CYC);
            K_SECT:  wr_len = CNT_W'(SE_CYC);
            K_BLK:   wr_len = CNT_W'(BE_CYC);
            K_CHIP:  wr_len = CNT_W'(CE_CYC);
            K_WRSR:  wr_len = CNT_W'(SR_CYC);
            default: is_write = 1'b0;
        endcase
    end

    // next state and timer control
    always_comb begin
        nxt  = state;
        load = 1'b0;
        len  = '0;
        take = 1'b0;
        unique case (state)
            M_STANDBY, M_SELECTED: begin
                if (state == M_STANDBY && !cs_n) nxt = M_SELECTED;   // select
                if (state == M_SELECTED && cs_n) nxt = M_STANDBY;    // deselect
                if (cmd_end) begin
                    if (is_write) begin
                        if (wel) begin                               // write start
                            take = 1'b1;
                            load = 1'b1;
                            len  = wr_len;
                            nxt  = M_BUSY;
                        end
                    end else begin
                        case (kind)
                            K_WREN, K_WRDI, K_WAKE: begin
                                take = 1'b1;
                                nxt  = M_STANDBY;
                            end
                            K_SLEEP: begin                           // sleep
                                take = 1'b1;
                                load = 1'b1;
                                len  = CNT_W'(DP_CYC);
                                nxt  = M_SLEEPING;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            M_BUSY:     if (expired) nxt = M_STANDBY;                // write done
            M_SLEEPING: if (expired) nxt = M_ASLEEP;                 // sleep done
            M_ASLEEP: begin
                if (cmd_end && kind == K_WAKE) begin                 // wake
                    take = 1'b1;
                    load = 1'b1;
                    len  = CNT_W'(RES_CYC);
                    nxt  = M_WAKING;
                end
            end
            M_WAKING:   if (expired) nxt = M_STANDBY;                // wake done
            default:    nxt = M_STANDBY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_STANDBY;
        else        state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel       <= 1'b0;
            busy_done <= 1'b0;
            cmd_taken <= 1'b0;
        end else begin
            busy_done <= (state == M_BUSY) && expired;
            cmd_taken <= take;
            if ((state == M_BUSY) && expired)
                wel <= 1'b0;
            else if (take && kind == K_WREN)
                wel <= 1'b1;
            else if (take && kind == K_WRDI)
                wel <= 1'b0;
        end
    end

    assign mode = state;
    assign wip  = (state == M_BUSY);
endmodule

// File: rtl/flash_pwr_chk.sv
module flash_pwr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_end,
    input logic [2:0] mode,
    input logic       wip,
    input logic       wel,
    input logic       busy_done,
    input logic       cmd_taken
);
    p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_done |-> ($past(wip) && !wip && !wel));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_done |=> !busy_done);

    p_busy_keeps_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && $past(wip)) |-> $stable(wel));

    p_asleep_from_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |-> ($past(mode) == 3'd3 || $past(mode) == 3'd4));

    p_asleep_keeps_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && $past(mode) == 3'd4) |-> $stable(wel));

    p_wake_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 3'd5 && mode != 3'd5) |-> (mode == 3'd0));

    p_taken_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_taken |-> $past(cmd_end));
endmodule

bind flash_pwr_ctrl flash_pwr_chk i_chk (.*);

// File: tb/test_flash_pwr_ctrl.sv
`timescale 1ns/1ps
module test_flash_pwr_ctrl;
    localparam int PP = 9, SE = 14, BE = 17, CE = 21, SR = 6, DP = 5, RES = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       cmd_end = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic [2:0] mode;
    logic       wip, wel, busy_done, cmd_taken;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;
    int done_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_pwr_ctrl #(.PP_CYC(PP), .SE_CYC(SE), .BE_CYC(BE), .CE_CYC(CE),
                     .SR_CYC(SR), .DP_CYC(DP), .RES_CYC(RES)) i_flash_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_end(cmd_end), .cmd_code(cmd_code),
        .mode(mode), .wip(wip), .wel(wel), .busy_done(busy_done), .cmd_taken(cmd_taken));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // chip select low one cycle, then rise with the opcode; returns at the
    // negedge after the edge that sampled cmd_end
    task automatic send(input logic [7:0] op);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) begin cs_n = 1'b1; cmd_end = 1'b1; cmd_code = op; end
        @(negedge clk) cmd_end = 1'b0;
    endtask

    task automatic wait_standby();
        for (int i = 0; i < 300 && mode != 3'd0; i++) @(negedge clk);
    endtask

    // scoreboard monitor: completion pulses must come in the predicted cycles
    always @(negedge clk) begin
        if (rst_n && busy_done && !finished) begin
            if (done_q.size() == 0) begin
                check("R4 unexpected busy_done", 1, 0);
            end else begin
                int exp_c;
                exp_c = done_q.pop_front();
                check("R3 busy length (done cycle)", cyc, exp_c);
                check("R4 wip low at done", int'(wip), 0);
                check("R4 wel low at done", int'(wel), 0);
            end
        end
    end

    // watchdog
    initial begin
        #(5ns * 100000);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [7] = '{8'h02, 8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7, 8'h01};
        int         lens[7] = '{PP, SE, BE, BE, CE, CE, SR};

        repeat (3) @(negedge clk);
        check("R1 mode", int'(mode), 0);
        check("R1 wip", int'(wip), 0);
        check("R1 wel", int'(wel), 0);
        check("R1 busy_done", int'(busy_done), 0);
        check("R1 cmd_taken", int'(cmd_taken), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 select / deselect
        cs_n = 1'b0;
        @(negedge clk) check("R11 selected", int'(mode), 1);
        cs_n = 1'b1;
        @(negedge clk) check("R11 back to standby", int'(mode), 0);

        // R5 write without latch
        send(8'h02);
        check("R5 not taken", int'(cmd_taken), 0);
        check("R5 mode", int'(mode), 0);

        // R2 enable and disable
        send(8'h06);
        check("R2 wel set", int'(wel), 1);
        check("R2 taken", int'(cmd_taken), 1);
        send(8'h04);
        check("R2 wel cleared", int'(wel), 0);
        check("R2 taken", int'(cmd_taken), 1);

        // R3/R4 every write opcode
        for (int k = 0; k < 7; k++) begin
            send(8'h06);
            send(ops[k]);
            done_q.push_back(cyc + lens[k]);
            check("R3 busy mode", int'(mode), 2);
            check("R3 wip high", int'(wip), 1);
            check("R3 taken", int'(cmd_taken), 1);
            if (k == 0) begin
                send(8'h04);
                check("R6 wrdi ignored taken", int'(cmd_taken), 0);
                check("R6 wel kept", int'(wel), 1);
                send(8'hAB);
                check("R6 release ignored", int'(mode), 2);
            end
            wait_standby();
            @(negedge clk);
            check("R4 wel clear after cycle", int'(wel), 0);
            check("R4 mode standby", int'(mode), 0);
        end

        // R12 neutral opcode
        send(8'h03);
        check("R12 not taken", int'(cmd_taken), 0);
        check("R12 mode", int'(mode), 0);

        // R10 release from standby
        send(8'hAB);
        check("R10 taken", int'(cmd_taken), 1);
        check("R10 immediate standby", int'(mode), 0);

        // R7 power down entry
        send(8'hB9);
        check("R7 entering", int'(mode), 3);
        repeat (DP - 1) @(negedge clk);
        check("R7 still entering", int'(mode), 3);
        @(negedge clk) check("R7 asleep", int'(mode), 4);

        // R8 ignored while asleep
        send(8'h06);
        check("R8 wren not taken", int'(cmd_taken), 0);
        check("R8 wel stays 0", int'(wel), 0);
        send(8'h02);
        check("R8 write ignored", int'(mode), 4);
        send(8'hB9);
        check("R8 sleep ignored", int'(mode), 4);

        // R9 timed release
        send(8'hAB);
        check("R9 waking", int'(mode), 5);
        check("R9 taken", int'(cmd_taken), 1);
        repeat (RES - 1) @(negedge clk);
        check("R9 still waking", int'(mode), 5);
        @(negedge clk) check("R9 standby", int'(mode), 0);

        repeat (3) @(negedge clk);
        check("R3 all completions seen", done_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule